// File: doc/BRIEF.md
# Amplifier Power-Mode Sequencer

This block orders the three power controls of a speaker amplifier: the supply enable, the standby level and the speaker-save (output mute) level. The ordering keeps the speaker from popping when it is switched. A host raises an enable request, and the block then turns on the supplies. It waits out the supply ramp and confirms that the supplies are good. It then releases standby, waits for the internal bias to settle, and only after that releases speaker save. When the request drops, both save and standby are asserted together, and the supplies are removed only after a ramp-down allowance.

All delays are counted in clock ticks. The tick counts come from the clock rate in kHz and the delays in milliseconds, which are parameters. One down-counter is shared by the ramp wait and the settle wait. A shutdown input, or the loss of supply-good after the ramp, drops the amplifier to the off state within one cycle. The output levels are suitable for a register writer that forwards them to the amplifier.

Top module: `amp_pwr_seq`

## Requirements
- R1: After reset, and whenever the block is off, the outputs are supply_en=0, standby=1, spk_save=1 and busy=0. Written as the vector {supply_en,standby,spk_save,busy}, this is 0110.
- R2: With the block off and shutdown low, a high en_req makes the outputs 1111 on the next cycle: supplies on, standby and save still asserted, busy high.
- R3: Standby is released (vector 1011) only after supply_en has been high for RAMP_TICKS cycles and supply_good is high. If supply_good arrives later than that, standby is released on the cycle after supply_good is first seen high.
- R4: Speaker save is released exactly SETTLE_TICKS cycles after standby is released. The block is then fully on (vector 1000), and save is never released while standby is asserted.
- R5: When en_req drops while the block is fully on, save and standby are asserted in the same cycle, on the next cycle (vector 1111). The supplies stay on for RAMP_TICKS cycles and then switch off (vector 0110).
- R6: When en_req drops during power-up, before the block is fully on, the sequence is abandoned on the next cycle. The block takes the same power-down path, with save and standby asserted together.
- R7: A high shutdown forces the off outputs on the next cycle from any state. While shutdown stays high, en_req is ignored. Once shutdown is released, a held request starts a new power-up on the next cycle.
- R8: Once the supply ramp has completed, a low supply_good forces the off outputs on the next cycle. This takes precedence over a simultaneous drop of en_req.
- R9: busy is high in every state except fully off and fully on.
- R10: A request raised during power-down does not cut the power-down short. The supplies still switch off after the full ramp-down allowance, and a new power-up begins on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all delays are counted in its ticks |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Level request to power the amplifier on |
| supply_good | input | 1 | Supply rails are within range |
| shutdown | input | 1 | Forces the off state immediately |
| supply_en | output | 1 | Enables the amplifier supply rails |
| standby | output | 1 | Amplifier standby level, 1 = standby asserted |
| spk_save | output | 1 | Speaker-save (mute) level, 1 = save asserted |
| busy | output | 1 | A power-up or power-down sequence is in progress |

## Verification
Each input change is sampled by one edge, and the outputs are decoded directly from the state register. A change of en_req, shutdown or supply_good is therefore due one cycle later. Standby release follows RAMP_TICKS cycles after the supplies come on, save release follows SETTLE_TICKS cycles after that, and supply removal follows RAMP_TICKS cycles after power-down starts. The bench keeps a free-running cycle count. For each stimulus it queues every output change with the exact cycle that these counts predict. A monitor samples the outputs on the falling edge and matches each change it sees against the head of that queue, so a change that comes early, late or unannounced is reported as a failure.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_RAMP   = 3'd1,
        PS_SETTLE = 3'd2,
        PS_ON     = 3'd3,
        PS_DOWN   = 3'd4
    } pstate_e;

    typedef struct packed {
        logic supply_en;
        logic standby;
        logic spk_save;
        logic busy;
    } pctl_t;

    function automatic int unsigned ms_to_ticks(input int unsigned khz,
                                                input int unsigned ms);
        return khz * ms;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic pctl_t decode_state(input pstate_e s);
        pctl_t c;
        case (s)
            PS_RAMP:   c = '{supply_en: 1'b1, standby: 1'b1, spk_save: 1'b1, busy: 1'b1};
            PS_SETTLE: c = '{supply_en: 1'b1, standby: 1'b0, spk_save: 1'b1, busy: 1'b1};
            PS_ON:     c = '{supply_en: 1'b1, standby: 1'b0, spk_save: 1'b0, busy: 1'b0};
            PS_DOWN:   c = '{supply_en: 1'b1, standby: 1'b1, spk_save: 1'b1, busy: 1'b1};
            default:   c = '{supply_en: 1'b0, standby: 1'b1, spk_save: 1'b1, busy: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int RAMP_TICKS   = 10,
    parameter int SETTLE_TICKS = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic             supply_good,
    input  logic             shutdown,
    input  logic             expired,
    output pstate_e          state,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] RAMP_LD   = CNT_W'(RAMP_TICKS - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_TICKS - 1);

    pstate_e nxt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = RAMP_LD;
        if (shutdown) begin
            nxt = PS_OFF;
        end else begin
            case (state)
                PS_OFF: begin
                    if (en_req) begin
                        nxt  = PS_RAMP;
                        load = 1'b1;
                    end
                end
                PS_RAMP: begin
                    if (!en_req) begin
                        nxt  = PS_DOWN;
                        load = 1'b1;
                    end else if (expired && supply_good) begin
                        nxt      = PS_SETTLE;
                        load     = 1'b1;
                        load_val = SETTLE_LD;
                    end
                end
                PS_SETTLE: begin
                    if (!supply_good) begin
                        nxt = PS_OFF;
                    end else if (!en_req) begin
                        nxt  = PS_DOWN;
                        load = 1'b1;
                    end else if (expired) begin
                        nxt = PS_ON;
                    end
                end
                PS_ON: begin
                    if (!supply_good) begin
                        nxt = PS_OFF;
                    end else if (!en_req) begin
                        nxt  = PS_DOWN;
                        load = 1'b1;
                    end
                end
                PS_DOWN: begin
                    if (!supply_good || expired)
                        nxt = PS_OFF;
                end
                default: nxt = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= PS_OFF;
        else
            state <= nxt;
    end
endmodule

// File: rtl/pwrseq_outmap.sv
module pwrseq_outmap
    import pwrseq_pkg::*;
(
    input  pstate_e state,
    output pctl_t   ctl
);
    always_comb ctl = decode_state(state);
endmodule

// File: rtl/amp_pwr_seq.sv
module amp_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 250000,
    parameter int unsigned RAMP_MS   = 1,
    parameter int unsigned SETTLE_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic supply_good,
    input  logic shutdown,
    output logic supply_en,
    output logic standby,
    output logic spk_save,
    output logic busy
);
    localparam int unsigned RAMP_TICKS   = ms_to_ticks(CLK_KHZ, RAMP_MS);
    localparam int unsigned SETTLE_TICKS = ms_to_ticks(CLK_KHZ, SETTLE_MS);
    localparam int unsigned MAX_TICKS    = max_u(RAMP_TICKS, SETTLE_TICKS);
    localparam int          CNT_W        = $clog2(MAX_TICKS + 1);

    pstate_e          state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    pctl_t            ctl;

    pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pwrseq_fsm #(
        .CNT_W        (CNT_W),
        .RAMP_TICKS   (int'(RAMP_TICKS)),
        .SETTLE_TICKS (int'(SETTLE_TICKS))
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en_req      (en_req),
        .supply_good (supply_good),
        .shutdown    (shutdown),
        .expired     (tmr_expired),
        .state       (state),
        .load        (tmr_load),
        .load_val    (tmr_val)
    );

    pwrseq_outmap u_outmap (
        .state (state),
        .ctl   (ctl)
    );

    assign supply_en = ctl.supply_en;
    assign standby   = ctl.standby;
    assign spk_save  = ctl.spk_save;
    assign busy      = ctl.busy;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int unsigned RAMP_TICKS   = 10,
    parameter int unsigned SETTLE_TICKS = 200
) (
    input logic clk,
    input logic rst,
    input logic en_req,
    input logic supply_good,
    input logic shutdown,
    input logic supply_en,
    input logic standby,
    input logic spk_save,
    input logic busy
);
    logic [31:0] en_run;
    logic [31:0] stby_low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_run       <= '0;
            stby_low_run <= '0;
        end else begin
            en_run       <= !supply_en ? '0 : (en_run == '1 ? en_run : en_run + 1);
            stby_low_run <= standby ? '0 : (stby_low_run == '1 ? stby_low_run : stby_low_run + 1);
        end
    end

    // R4
    save_order_chk: assert property (@(posedge clk) disable iff (rst)
        !spk_save |-> !standby);

    // R3
    stby_order_chk: assert property (@(posedge clk) disable iff (rst)
        !standby |-> supply_en);

    // R3
    ramp_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(standby) |-> en_run >= RAMP_TICKS);

    // R4
    settle_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spk_save) |-> stby_low_run >= SETTLE_TICKS);

    // R5
    down_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(supply_en) && !$past(shutdown) && $past(supply_good))
            |-> ($past(spk_save) && $past(standby)));

    // R7
    shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (!supply_en && standby && spk_save));

    // R9
    busy_map_chk: assert property (@(posedge clk) disable iff (rst)
        busy == !((supply_en && !standby && !spk_save) ||
                  (!supply_en && standby && spk_save)));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_en && en_req && !shutdown) |=> supply_en);
endmodule

bind amp_pwr_seq pwrseq_chk #(
    .RAMP_TICKS   (RAMP_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS)
) u_pwrseq_chk (
    .clk         (clk),
    .rst         (rst),
    .en_req      (en_req),
    .supply_good (supply_good),
    .shutdown    (shutdown),
    .supply_en   (supply_en),
    .standby     (standby),
    .spk_save    (spk_save),
    .busy        (busy)
);

// File: tb/tb_amp_pwr_seq.sv
`timescale 1ns/1ps
module tb_amp_pwr_seq;
    localparam int R = 10;
    localparam int S = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_req = 1'b0;
    logic supply_good = 1'b0;
    logic shutdown = 1'b0;
    logic supply_en, standby, spk_save, busy;

    always #2 clk = ~clk;

    amp_pwr_seq #(.CLK_KHZ(10), .RAMP_MS(1), .SETTLE_MS(20)) dut (
        .clk(clk), .rst(rst), .en_req(en_req), .supply_good(supply_good),
        .shutdown(shutdown), .supply_en(supply_en), .standby(standby),
        .spk_save(spk_save), .busy(busy)
    );

    typedef struct {
        int        cyc;
        logic [3:0] val;
        string     req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [3:0] prev;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] outs();
        return {supply_en, standby, spk_save, busy};
    endfunction

    task automatic expect_at(input int c, input logic [3:0] v, input string req);
        exp_t e;
        e.cyc = c; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic check_now(input logic [3:0] v, input string req);
        checks++;
        if (outs() !== v) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at cycle %0d", req, outs(), v, cyc);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: every output change must match the head of the queue
    initial begin
        @(negedge clk);
        prev = outs();
        forever begin
            @(negedge clk);
            if (!rst && outs() !== prev) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected change: outputs %b expected %b at cycle %0d",
                             outs(), prev, cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.val !== outs() || e.cyc != cyc) begin
                        errors++;
                        $display("FAIL %s: outputs %b at cycle %0d expected %b at cycle %0d",
                                 e.req, outs(), cyc, e.val, e.cyc);
                    end
                end
            end
            prev = outs();
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run ended at cycle %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_now(4'b0110, "R1 reset state");

        // R2 R3 R4: normal power-up, supplies already good
        supply_good = 1'b1;
        t = cyc; en_req = 1'b1;
        expect_at(t + 1, 4'b1111, "R2 supplies on");
        expect_at(t + 1 + R, 4'b1011, "R3 standby release");
        expect_at(t + 1 + R + S, 4'b1000, "R4 save release");
        wait_to(t + R + S + 5);
        check_now(4'b1000, "R9 busy low when on");

        // R5: power-down from on
        t = cyc; en_req = 1'b0;
        expect_at(t + 1, 4'b1111, "R5 save and standby together");
        expect_at(t + 1 + R, 4'b0110, "R5 supplies off");
        wait_to(t + R + 5);
        check_now(4'b0110, "R9 busy low when off");

        // R3: late supply_good extends the ramp wait
        supply_good = 1'b0;
        t = cyc; en_req = 1'b1;
        expect_at(t + 1, 4'b1111, "R2 supplies on");
        wait_to(t + R + 5);
        check_now(4'b1111, "R3 standby held without supply_good");
        supply_good = 1'b1;
        expect_at(t + R + 6, 4'b1011, "R3 standby after late good");
        expect_at(t + R + 6 + S, 4'b1000, "R4 save release");
        wait_to(t + R + S + 10);

        // R7: shutdown forces off and blocks the held request
        t = cyc; shutdown = 1'b1;
        expect_at(t + 1, 4'b0110, "R7 shutdown off");
        wait_to(t + 20);
        check_now(4'b0110, "R7 request ignored in shutdown");
        t = cyc; shutdown = 1'b0;
        expect_at(t + 1, 4'b1111, "R7 restart after shutdown");
        expect_at(t + 1 + R, 4'b1011, "R3 standby release");
        // R6: abort while settling
        wait_to(t + 1 + R + 20);
        t = cyc; en_req = 1'b0;
        expect_at(t + 1, 4'b1111, "R6 abort from settle");
        expect_at(t + 1 + R, 4'b0110, "R6 supplies off after abort");
        wait_to(t + R + 5);

        // R6: abort during the ramp (outputs equal, timing shows the abort)
        t = cyc; en_req = 1'b1;
        expect_at(t + 1, 4'b1111, "R2 supplies on");
        wait_to(t + 3);
        en_req = 1'b0;
        expect_at(t + 4 + R, 4'b0110, "R6 abort from ramp");
        wait_to(t + 2 * R + S);
        check_now(4'b0110, "R6 stays off after abort");

        // R8: supply loss in the on state beats the disable
        t = cyc; en_req = 1'b1;
        expect_at(t + 1, 4'b1111, "R2 supplies on");
        expect_at(t + 1 + R, 4'b1011, "R3 standby release");
        expect_at(t + 1 + R + S, 4'b1000, "R4 save release");
        wait_to(t + R + S + 5);
        t = cyc; supply_good = 1'b0; en_req = 1'b0;
        expect_at(t + 1, 4'b0110, "R8 supply loss forces off");
        wait_to(t + R + 10);
        check_now(4'b0110, "R8 off after supply loss");
        supply_good = 1'b1;

        // R10: request during power-down
        t = cyc; en_req = 1'b1;
        expect_at(t + 1, 4'b1111, "R2 supplies on");
        expect_at(t + 1 + R, 4'b1011, "R3 standby release");
        expect_at(t + 1 + R + S, 4'b1000, "R4 save release");
        wait_to(t + R + S + 5);
        t = cyc; en_req = 1'b0;
        expect_at(t + 1, 4'b1111, "R10 power-down starts");
        wait_to(t + 3);
        en_req = 1'b1;
        expect_at(t + 1 + R, 4'b0110, "R10 power-down completes");
        expect_at(t + 2 + R, 4'b1111, "R10 restart after off");
        expect_at(t + 2 + 2 * R, 4'b1011, "R10 standby release");
        expect_at(t + 2 + 2 * R + S, 4'b1000, "R10 save release");
        wait_to(t + 2 * R + S + 10);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected changes missing, expected 0", q[0].req, q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule